// File: doc/BRIEF.md
# PCI Host Bridge Address Decoder

This block sits between a CPU-side request port and the configuration and interrupt machinery of a PCI host bridge. Each request (memory or I/O, read or write) is decoded once and sent to one target. A direct-mapped memory window turns one-hot device-select address bits into a binary device number and forwards a configuration transaction. The index/data I/O port pair forwards a configuration transaction through a latched index. A fixed memory address runs an interrupt-acknowledge cycle against an interrupt-controller stub. Requests that hit none of these complete locally.

Only one request is in flight at a time. The request port stalls until the downstream target answers. Every accepted request, read or write, ends with exactly one single-cycle response pulse. Writes respond with zero. A separate, free-running router ORs the PCI interrupt pins of each device onto host interrupt lines and registers the result.

Top module: `hb_addr_route`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, cfg_valid and iack_valid are 0, host_irq is all zero, and the configuration index reads back as 0.
- R2: A memory request with address bits 31:22 equal to 0x202 (window 0x8080_0000, 4 MiB) becomes a configuration access. Its cfg_addr has bits 10:0 equal to the request's bits 10:0, and bits 14:11 equal to the index k of the lowest set bit among request bits 11+k (k = 0..10). Bits 31:15 are zero.
- R3: A window request with none of address bits 21:11 set makes no configuration cycle. A read responds with 0xFFFF_FFFF and a write is discarded (response 0).
- R4: Window data passes unchanged in both directions: cfg_wdata equals req_wdata, and the response equals cfg_rdata.
- R5: An I/O write to port 0xCF8 loads the index with req_wdata byte-reversed. An I/O read of 0xCF8 returns the index byte-reversed.
- R6: An I/O access to port 0xCFC makes a configuration cycle with cfg_addr equal to the index. Write data and read data are byte-reversed.
- R7: A one-byte (req_size 0) memory read of 0xBFFF_FFF0 raises iack_valid until iack_ready, then responds with {24'h0, iack_vector}.
- R8: At 0xBFFF_FFF0, a read wider than one byte, or any write, runs no acknowledge cycle. The read responds with 0xFFFF_FFFF and the write responds with 0.
- R9: Any other memory or I/O address runs no downstream cycle. A read responds with 0xFFFF_FFFF and a write responds with 0.
- R10: cfg_valid and its address, data and direction hold steady until cfg_ready. req_ready is 0 while a request is outstanding. rsp_valid lasts exactly one cycle, and is raised the cycle after the downstream handshake.
- R11: pci_intx bit d*4+p (device d, pin p = 0..3) drives host_irq line (p+d) mod 2, registered one clock later. Lines 2 and 3 stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_size | input | 2 | Access size: 0 = byte, 1 = half, 2 = word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| cfg_valid | output | 1 | Configuration transaction pending |
| cfg_ready | input | 1 | Configuration target completes |
| cfg_write | output | 1 | Configuration write |
| cfg_addr | output | 32 | Configuration address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_ready |
| iack_valid | output | 1 | Interrupt-acknowledge cycle pending |
| iack_ready | input | 1 | Controller supplies the vector |
| iack_vector | input | 8 | Interrupt vector |
| pci_intx | input | NUM_DEV*4 | PCI interrupt pins, device-major |
| host_irq | output | 4 | Host interrupt lines |

## Verification
The bench builds the block with NUM_DEV set to 3, so each host line collects pins from an odd number of devices. Device 2, pin 3 tests the mod-2 wrap, and the remaining parameters keep their defaults. The configuration target stub answers after zero to three wait cycles, which exercises the stalled-handshake hold. The device-select tests cover the lowest, a middle, and the highest select bit, and also the case with no select bit.

// File: rtl/hb_pkg.sv
// Package: shared types and helpers for the host bridge decoder.
// Assumes 32-bit data; byte reversal is defined for that width.
package hb_pkg;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CFG_WIN,
        TGT_CFG_IDX,
        TGT_IACK,
        TGT_IDX_WR,
        TGT_IDX_RD
    } hb_target_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CFG,
        ST_IACK,
        ST_RSP
    } hb_state_e;

    // Reverse the byte order of a 32-bit word.
    function automatic logic [31:0] bswap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/hb_idsel_enc.sv
// Priority encoder: returns the index of the lowest set select bit,
// or SEL_N when none is set. Purely combinational.
module hb_idsel_enc #(
    parameter int SEL_N = 11,
    parameter int OUT_W = $clog2(SEL_N + 1)
) (
    input  logic [SEL_N-1:0] sel,
    output logic [OUT_W-1:0] dev,
    output logic             none
);

    // Scan from the top down so the lowest set bit wins last.
    always_comb begin
        dev = OUT_W'(SEL_N);
        for (int i = SEL_N - 1; i >= 0; i--) begin
            if (sel[i]) dev = OUT_W'(i);
        end
    end

    // Flag the no-select case.
    assign none = (sel == '0);

endmodule

// File: rtl/hb_decode.sv
// Address decoder: classifies one request into a target and builds the
// direct-window configuration address. Combinational; assumes the window
// base is aligned to its power-of-two span.
module hb_decode
    import hb_pkg::*;
#(
    parameter logic [31:0] CFG_WIN_BASE = 32'h8080_0000,
    parameter logic [31:0] CFG_WIN_SPAN = 32'h0040_0000,
    parameter logic [31:0] IACK_ADDR    = 32'hBFFF_FFF0,
    parameter logic [31:0] IO_INDEX     = 32'h0000_0CF8,
    parameter logic [31:0] IO_DATA      = 32'h0000_0CFC,
    parameter int          SEL_LSB      = 11,
    parameter int          SEL_N        = 11
) (
    input  logic        is_io,
    input  logic        write,
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    output hb_target_e  target,
    output logic        absent,
    output logic [31:0] win_cfg_addr
);

    localparam int DEV_W = $clog2(SEL_N + 1);

    logic [DEV_W-1:0] dev_num;
    logic             no_sel;
    logic             in_win;

    hb_idsel_enc #(.SEL_N(SEL_N), .OUT_W(DEV_W)) u_enc (
        .sel  (addr[SEL_LSB +: SEL_N]),
        .dev  (dev_num),
        .none (no_sel)
    );

    assign in_win = ((addr & ~(CFG_WIN_SPAN - 32'd1)) == CFG_WIN_BASE);

    // Device number above the untouched function/register bits.
    assign win_cfg_addr = (32'(dev_num) << SEL_LSB) | 32'(addr[SEL_LSB-1:0]);
    assign absent       = no_sel;

    // Pick the one target this request belongs to.
    always_comb begin
        target = TGT_NONE;
        if (is_io) begin
            if (addr == IO_INDEX)     target = write ? TGT_IDX_WR : TGT_IDX_RD;
            else if (addr == IO_DATA) target = TGT_CFG_IDX;
        end else begin
            if (in_win) target = TGT_CFG_WIN;
            else if (addr == IACK_ADDR && !write && size == 2'd0) target = TGT_IACK;
        end
    end

endmodule

// File: rtl/hb_irq_map.sv
// Interrupt router: ORs every device pin onto host line (pin+dev) mod 2,
// then registers each line once. Assumes pins are packed device-major.
module hb_irq_map #(
    parameter int NUM_DEV   = 4,
    parameter int NUM_PINS  = 4,
    parameter int NUM_LINES = 4,
    parameter int ROUTE_MOD = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_DEV*NUM_PINS-1:0] intx,
    output logic [NUM_LINES-1:0]        lines
);

    logic [NUM_LINES-1:0] merged;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        // Collect every pin whose route lands on this line.
        always_comb begin
            merged[l] = 1'b0;
            for (int d = 0; d < NUM_DEV; d++) begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (((p + d) % ROUTE_MOD) == l) merged[l] = merged[l] | intx[d*NUM_PINS+p];
                end
            end
        end
    end

    // Register the merged lines to strip combinational glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) lines <= '0;
        else        lines <= merged;
    end

endmodule

// File: rtl/hb_addr_route.sv
// Host bridge address decoder top: accepts one request at a time, routes
// it to the configuration bus, the acknowledge stub or a local reply, and
// returns a one-cycle response. Assumes a single requester.
module hb_addr_route
    import hb_pkg::*;
#(
    parameter logic [31:0] CFG_WIN_BASE = 32'h8080_0000,
    parameter logic [31:0] CFG_WIN_SPAN = 32'h0040_0000,
    parameter logic [31:0] IACK_ADDR    = 32'hBFFF_FFF0,
    parameter logic [31:0] IO_INDEX     = 32'h0000_0CF8,
    parameter logic [31:0] IO_DATA      = 32'h0000_0CFC,
    parameter int          SEL_LSB      = 11,
    parameter int          SEL_N        = 11,
    parameter int          NUM_DEV      = 4,
    parameter int          NUM_PINS     = 4,
    parameter int          NUM_LINES    = 4,
    parameter int          VEC_W        = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_is_io,
    input  logic                        req_write,
    input  logic [31:0]                 req_addr,
    input  logic [1:0]                  req_size,
    input  logic [31:0]                 req_wdata,
    output logic                        rsp_valid,
    output logic [31:0]                 rsp_rdata,
    output logic                        cfg_valid,
    input  logic                        cfg_ready,
    output logic                        cfg_write,
    output logic [31:0]                 cfg_addr,
    output logic [31:0]                 cfg_wdata,
    input  logic [31:0]                 cfg_rdata,
    output logic                        iack_valid,
    input  logic                        iack_ready,
    input  logic [VEC_W-1:0]            iack_vector,
    input  logic [NUM_DEV*NUM_PINS-1:0] pci_intx,
    output logic [NUM_LINES-1:0]        host_irq
);

    localparam logic [31:0] ALL_ONES = '1;

    hb_target_e  tgt;
    logic        absent;
    logic [31:0] win_addr;
    hb_state_e   state;
    logic [31:0] index_q;
    logic        swap_q;
    logic        write_q;
    logic        accept;

    hb_decode #(
        .CFG_WIN_BASE (CFG_WIN_BASE),
        .CFG_WIN_SPAN (CFG_WIN_SPAN),
        .IACK_ADDR    (IACK_ADDR),
        .IO_INDEX     (IO_INDEX),
        .IO_DATA      (IO_DATA),
        .SEL_LSB      (SEL_LSB),
        .SEL_N        (SEL_N)
    ) u_dec (
        .is_io        (req_is_io),
        .write        (req_write),
        .addr         (req_addr),
        .size         (req_size),
        .target       (tgt),
        .absent       (absent),
        .win_cfg_addr (win_addr)
    );

    hb_irq_map #(
        .NUM_DEV   (NUM_DEV),
        .NUM_PINS  (NUM_PINS),
        .NUM_LINES (NUM_LINES),
        .ROUTE_MOD (2)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .intx  (pci_intx),
        .lines (host_irq)
    );

    assign req_ready  = (state == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign cfg_valid  = (state == ST_CFG);
    assign iack_valid = (state == ST_IACK);
    assign rsp_valid  = (state == ST_RSP);
    assign cfg_write  = write_q;

    // Sequence one request from acceptance through its response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            index_q   <= '0;
            swap_q    <= 1'b0;
            write_q   <= 1'b0;
            cfg_addr  <= '0;
            cfg_wdata <= '0;
            rsp_rdata <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        write_q <= req_write;
                        case (tgt)
                            TGT_CFG_WIN: begin
                                if (absent) begin
                                    rsp_rdata <= req_write ? '0 : ALL_ONES;
                                    state     <= ST_RSP;
                                end else begin
                                    cfg_addr  <= win_addr;
                                    cfg_wdata <= req_wdata;
                                    swap_q    <= 1'b0;
                                    state     <= ST_CFG;
                                end
                            end
                            TGT_CFG_IDX: begin
                                cfg_addr  <= index_q;
                                cfg_wdata <= bswap32(req_wdata);
                                swap_q    <= 1'b1;
                                state     <= ST_CFG;
                            end
                            TGT_IACK: state <= ST_IACK;
                            TGT_IDX_WR: begin
                                index_q   <= bswap32(req_wdata);
                                rsp_rdata <= '0;
                                state     <= ST_RSP;
                            end
                            TGT_IDX_RD: begin
                                rsp_rdata <= bswap32(index_q);
                                state     <= ST_RSP;
                            end
                            default: begin
                                rsp_rdata <= req_write ? '0 : ALL_ONES;
                                state     <= ST_RSP;
                            end
                        endcase
                    end
                end
                ST_CFG: begin
                    if (cfg_ready) begin
                        if (write_q)     rsp_rdata <= '0;
                        else if (swap_q) rsp_rdata <= bswap32(cfg_rdata);
                        else             rsp_rdata <= cfg_rdata;
                        state <= ST_RSP;
                    end
                end
                ST_IACK: begin
                    if (iack_ready) begin
                        rsp_rdata <= 32'(iack_vector);
                        state     <= ST_RSP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hb_addr_route_chk.sv
// Checker: protocol properties of the decoder's downstream and response
// ports. Bound to every instance of the top module.
module hb_addr_route_chk #(
    parameter int NUM_DEV   = 4,
    parameter int NUM_PINS  = 4,
    parameter int NUM_LINES = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_ready,
    input logic                        rsp_valid,
    input logic [31:0]                 rsp_rdata,
    input logic                        cfg_valid,
    input logic                        cfg_ready,
    input logic                        cfg_write,
    input logic [31:0]                 cfg_addr,
    input logic [31:0]                 cfg_wdata,
    input logic                        iack_valid,
    input logic                        iack_ready,
    input logic [NUM_DEV*NUM_PINS-1:0] pci_intx,
    input logic [NUM_LINES-1:0]        host_irq
);

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_addr) &&
                                        $stable(cfg_wdata) && $stable(cfg_write)));

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_cfg_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_ready) |=> rsp_valid);

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid || iack_valid || rsp_valid) |-> !req_ready);

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cfg_valid, iack_valid, rsp_valid}) <= 1);

    p_iack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_valid && !iack_ready) |=> iack_valid);

    p_iack_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_valid && iack_ready) |=> (rsp_valid && rsp_rdata[31:8] == 24'h0));

    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_intx == '0) |=> (host_irq == '0));

    p_irq_any_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|pci_intx) |=> (|host_irq));

endmodule

bind hb_addr_route hb_addr_route_chk #(
    .NUM_DEV   (NUM_DEV),
    .NUM_PINS  (NUM_PINS),
    .NUM_LINES (NUM_LINES)
) u_chk (.*);

// File: tb/hb_addr_route_test.sv
// Scoreboard bench: a driver task queues expected responses and
// configuration cycles; monitors pop and compare as the design answers.
module hb_addr_route_test;

    localparam int NDEV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_io = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_size = '0;
    logic req_ready, rsp_valid, cfg_valid, cfg_write, iack_valid;
    logic [31:0] rsp_rdata, cfg_addr, cfg_wdata;
    logic cfg_ready = 1'b0, iack_ready = 1'b0;
    logic [31:0] cfg_rdata = '0;
    logic [7:0]  iack_vector = '0;
    logic [NDEV*4-1:0] pci_intx = '0;
    logic [3:0] host_irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int cfg_delay = 0, cfg_wait = 0, iack_wait = 0, iack_pend = 0;
    bit rsp_prev = 1'b0;

    logic [31:0] rsp_q[$];
    string       rsp_tag_q[$];
    logic [64:0] cfg_q[$];   // {write, addr, wdata}

    always #2.5 clk = ~clk;

    hb_addr_route #(.NUM_DEV(NDEV)) uut (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Response monitor: compare each pulse with the head of the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid && rsp_prev) check(1'b0, "R10 rsp pulse width", 64'd2, 64'd1);
            if (rsp_valid) begin
                if (rsp_q.size() == 0) check(1'b0, "R10 unexpected response", 64'(rsp_rdata), 64'd0);
                else begin
                    logic [31:0] e;
                    string t;
                    e = rsp_q.pop_front();
                    t = rsp_tag_q.pop_front();
                    check(rsp_rdata == e, t, 64'(rsp_rdata), 64'(e));
                end
            end
            rsp_prev = rsp_valid;
        end
    end

    // Configuration target stub with a programmable wait.
    always @(negedge clk) begin
        if (cfg_ready) cfg_ready = 1'b0;
        else if (cfg_valid) begin
            if (cfg_wait == cfg_delay) begin
                if (cfg_q.size() == 0) check(1'b0, "R3 unexpected cfg cycle", 64'(cfg_addr), 64'd0);
                else begin
                    logic [64:0] e;
                    e = cfg_q.pop_front();
                    check({cfg_write, cfg_addr, cfg_wdata} == e, "R2 R4 R6 cfg cycle",
                          {cfg_write, cfg_addr[30:0], cfg_wdata}, e[63:0]);
                end
                cfg_rdata = cfg_addr ^ 32'hA5A5_0000;
                cfg_ready = 1'b1;
                cfg_wait  = 0;
            end else cfg_wait++;
        end
    end

    // Interrupt-controller stub: answers after two waits with 0x2A.
    always @(negedge clk) begin
        if (iack_ready) iack_ready = 1'b0;
        else if (iack_valid) begin
            if (iack_wait == 2) begin
                if (iack_pend == 0) check(1'b0, "R8 unexpected iack", 64'd1, 64'd0);
                else iack_pend--;
                iack_vector = 8'h2A;
                iack_ready  = 1'b1;
                iack_wait   = 0;
            end else iack_wait++;
        end
    end

    task automatic issue(input bit io, input bit wr, input logic [31:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, input logic [31:0] exp, input string tag);
        rsp_q.push_back(exp);
        rsp_tag_q.push_back(tag);
        while (!req_ready) @(negedge clk);
        req_is_io = io; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R10 busy after accept", 64'(req_ready), 64'd0);
        while (rsp_q.size() != 0) @(negedge clk);
    endtask

    task automatic irq_case(input logic [NDEV*4-1:0] v, input logic [3:0] exp, input string tag);
        pci_intx = v;
        @(negedge clk);
        check(host_irq == exp, tag, 64'(host_irq), 64'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(req_ready && !rsp_valid && !cfg_valid && !iack_valid && host_irq == 4'h0,
              "R1 reset outputs", {req_ready, rsp_valid, cfg_valid, iack_valid, host_irq}, 64'h80);
        issue(1, 0, 32'h0CF8, 2'd2, '0, 32'h0, "R1 index reset");

        // R2 R4 window: lowest select bit, middle pair, highest bit with wait
        cfg_q.push_back({1'b0, 32'h0000_0104, 32'h0});
        issue(0, 0, 32'h8080_0904, 2'd2, '0, 32'hA5A5_0104, "R2 R4 dev0 read");
        cfg_q.push_back({1'b0, 32'h0000_100C, 32'h0});
        issue(0, 0, 32'h8080_A00C, 2'd2, '0, 32'hA5A5_100C, "R2 dev2 priority read");
        cfg_delay = 3;
        cfg_q.push_back({1'b1, 32'h0000_57FC, 32'h1122_3344});
        issue(0, 1, 32'h80A0_07FC, 2'd2, 32'h1122_3344, 32'h0, "R2 R4 R10 dev10 write");
        cfg_delay = 1;

        // R3 no select bit
        issue(0, 0, 32'h8080_0010, 2'd2, '0, 32'hFFFF_FFFF, "R3 absent read");
        issue(0, 1, 32'h8080_0010, 2'd2, 32'h55AA_55AA, 32'h0, "R3 absent write");

        // R5 index, R6 data port
        issue(1, 1, 32'h0CF8, 2'd2, 32'h0008_8080, 32'h0, "R5 index write");
        issue(1, 0, 32'h0CF8, 2'd2, '0, 32'h0008_8080, "R5 index readback");
        cfg_q.push_back({1'b0, 32'h8080_0800, 32'h0});
        issue(1, 0, 32'h0CFC, 2'd2, '0, 32'h0008_2525, "R6 data read");
        cfg_delay = 0;
        cfg_q.push_back({1'b1, 32'h8080_0800, 32'hEFBE_ADDE});
        issue(1, 1, 32'h0CFC, 2'd2, 32'hDEAD_BEEF, 32'h0, "R6 data write");

        // R7 acknowledge, R8 invalid forms
        iack_pend = 1;
        issue(0, 0, 32'hBFFF_FFF0, 2'd0, '0, 32'h0000_002A, "R7 iack byte read");
        issue(0, 0, 32'hBFFF_FFF0, 2'd2, '0, 32'hFFFF_FFFF, "R8 iack wide read");
        issue(0, 1, 32'hBFFF_FFF0, 2'd0, 32'h1, 32'h0, "R8 iack write");
        check(iack_pend == 0, "R7 iack cycle count", 64'(iack_pend), 64'd0);

        // R9 unmapped
        issue(0, 0, 32'h1000_0000, 2'd2, '0, 32'hFFFF_FFFF, "R9 mem read");
        issue(1, 0, 32'h0000_03F8, 2'd0, '0, 32'hFFFF_FFFF, "R9 io read");
        issue(1, 1, 32'h0000_03F8, 2'd0, 32'h7, 32'h0, "R9 io write");
        check(cfg_q.size() == 0, "R3 R6 cfg queue drained", 64'(cfg_q.size()), 64'd0);

        // R11 interrupt routing
        irq_case(12'h010, 4'b0010, "R11 dev1 pin0");
        irq_case(12'h001, 4'b0001, "R11 dev0 pin0");
        irq_case(12'h800, 4'b0010, "R11 dev2 pin3");
        irq_case(12'hFFF, 4'b0011, "R11 all pins");
        irq_case(12'h000, 4'b0000, "R11 released");

        done = 1'b1;
        report();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            report();
            $finish;
        end
    end

endmodule